// File: doc/BRIEF.md
# Audio PLL Reprogramming Sequencer

This block retunes an audio PLL to a new sample rate without software involvement. A rate-select code is sampled together with a one-cycle start pulse. The block looks up the feedback divider, post-divider and fractional frequency offset for that rate. It then walks the PLL's three configuration register images through a fixed, timed sequence:

1. Invalidate the offset and hold the PLL in reset.
2. Let it settle, then load the three parameters.
3. Let it settle again, then release reset.
4. Wait out the lock time and mark the offset valid once more.

All settle and lock delays are whole numbers of clock cycles, derived from the clock frequency parameter. The three register images drive the PLL directly. Bits outside the fields the sequencer owns keep whatever value they held, as a read-modify-write would leave them. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `apll_reprog_seq`

## Requirements
- R1: After reset, `busy` and `done` are low, and `cfg0`, `cfg1` and `cfg2` equal the `CFG0_INIT`, `CFG1_INIT` and `CFG2_INIT` parameters.
- R2: Rate codes select these parameter sets, written as offset / feedback divider / post-divider:
  - code 0 (44.1 kHz): 0x735 / 0x1B / 0xC
  - code 1 (48 kHz): 0x22B0 / 0x1D / 0xC
  - code 2 (96 kHz): 0x22B0 / 0x1D / 0x6
  - code 3 (192 kHz): 0x22B0 / 0x1D / 0x3

  The feedback divider is placed in `cfg0[18:10]`, the post-divider in `cfg2[6:0]` and the offset in `cfg1[15:0]`.
- R3: Any rate code above 3 produces the 44.1 kHz parameter set.
- R4: One cycle after an accepted start, `cfg1[16]` (offset valid) and `cfg1[31]` (reset release) both read 0.
- R5: `SETTLE_US*CLK_HZ/1e6` cycles after that, the parameters are written on three consecutive cycles: feedback divider, then post-divider, then offset. With N = settle cycles and start sampled at edge 0, these writes land at edges N+2, N+3 and N+4.
- R6: After a second settle wait, `cfg1[31]` is set at edge 2N+5. `cfg1[16]` is still 0 at that point.
- R7: After a lock wait of L = `LOCK_US*CLK_HZ/1e6` cycles, `cfg1[16]` is set at edge 2N+6+L. `done` rises on the same edge.
- R8: `busy` is high from edge 0 until the edge where `done` rises, and low from then on. A start pulse sampled while `busy` is high is ignored, including one sampled on the last busy cycle.
- R9: Bits of `cfg0`, `cfg1` and `cfg2` outside the owned fields never change. The owned fields are `cfg0[18:10]`, `cfg1[31]`, `cfg1[16:0]` and `cfg2[6:0]`.
- R10: `done` is high for exactly one cycle per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to retune; sampled only when idle |
| rate_sel | input | RATE_W | Rate code, sampled with `start` |
| cfg0 | output | 32 | Register image holding the feedback divider |
| cfg1 | output | 32 | Register image holding the offset, offset valid and reset release |
| cfg2 | output | 32 | Register image holding the post-divider |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence completes |

## Verification
The bench predicts every change of the five outputs, cycle by cycle, and rejects any change it did not predict. This catches a sequencer that writes a field early, swaps the order of the writes, or shortens a settle or lock wait: any of these makes a change land on the wrong cycle.

Several cases target specific faults:
- Rate codes above 3 are applied after a 48 kHz run, so a decoder that falls through to the 48 kHz set leaves `cfg0` and `cfg1` unchanged, and the predicted change never appears.
- Start pulses are injected mid-sequence and on the very last busy cycle. A design that restarts or re-latches the rate would issue an extra invalidation or pick up the wrong parameters.
- Reset values with many set bits outside the owned fields expose any write that clobbers neighbouring bits.

// File: rtl/apll_seq_pkg.sv
package apll_seq_pkg;

   // Register-image field positions (fixed by the PLL's register layout)
   localparam int unsigned CFG_W      = 32;
   localparam int unsigned FB_LSB     = 10;
   localparam int unsigned FB_W       = 9;
   localparam int unsigned PD_LSB     = 0;
   localparam int unsigned PD_W       = 7;
   localparam int unsigned OFS_LSB    = 0;
   localparam int unsigned OFS_W      = 16;
   localparam int unsigned VALID_BIT  = 16;
   localparam int unsigned RELEASE_BIT = 31;

   // Rate codes
   localparam int unsigned RATE_44K1 = 0;
   localparam int unsigned RATE_48K  = 1;
   localparam int unsigned RATE_96K  = 2;
   localparam int unsigned RATE_192K = 3;

   typedef struct packed {
      logic [OFS_W-1:0] ofs;
      logic [FB_W-1:0]  fb;
      logic [PD_W-1:0]  pd;
   } pll_param_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_INVAL,
      ST_WAIT_A,
      ST_WR_FB,
      ST_WR_PD,
      ST_WR_OFS,
      ST_WAIT_B,
      ST_RELEASE,
      ST_WAIT_LOCK,
      ST_VALID
   } seq_state_t;

   // Field masks derived from the positions above
   function automatic logic [CFG_W-1:0] field_mask(input int unsigned lsb, input int unsigned w);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int i = 0; i < CFG_W; i++) begin
         if (i >= lsb && i < lsb + w) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/apll_rate_lut.sv
module apll_rate_lut
   import apll_seq_pkg::*;
#(
   parameter int unsigned RATE_W = 3
) (
   input  logic [RATE_W-1:0] rate_sel,
   output pll_param_t        prm
);

   localparam int unsigned NUM_KNOWN = 4;

   initial begin
      assert (RATE_W >= 2)
         else $error("apll_rate_lut: RATE_W must encode at least four rates");
   end

   // Parameters shared by the 48 kHz family
   localparam logic [OFS_W-1:0] OFS_48 = 16'h22B0;
   localparam logic [FB_W-1:0]  FB_48  = 9'h01D;
   // 44.1 kHz family
   localparam logic [OFS_W-1:0] OFS_44 = 16'h0735;
   localparam logic [FB_W-1:0]  FB_44  = 9'h01B;

   logic known;

   generate
      if (RATE_W > 2) begin : g_wide
         assign known = (rate_sel < RATE_W'(NUM_KNOWN));
      end else begin : g_narrow
         assign known = 1'b1;
      end
   endgenerate

   always_comb begin
      prm.ofs = OFS_44;
      prm.fb  = FB_44;
      prm.pd  = 7'h0C;
      if (known) begin
         case (rate_sel[1:0])
            2'd1: begin
               prm.ofs = OFS_48;
               prm.fb  = FB_48;
               prm.pd  = 7'h0C;
            end
            2'd2: begin
               prm.ofs = OFS_48;
               prm.fb  = FB_48;
               prm.pd  = 7'h06;
            end
            2'd3: begin
               prm.ofs = OFS_48;
               prm.fb  = FB_48;
               prm.pd  = 7'h03;
            end
            default: begin
               prm.ofs = OFS_44;
               prm.fb  = FB_44;
               prm.pd  = 7'h0C;
            end
         endcase
      end
   end

endmodule

// File: rtl/apll_delay_timer.sv
module apll_delay_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R5 the count never wraps below zero
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/apll_seq_fsm.sv
module apll_seq_fsm
   import apll_seq_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned SETTLE_CYC = 50,
   parameter int unsigned LOCK_CYC   = 2500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  pll_param_t       prm_in,
   input  logic             tmr_expired,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output pll_param_t       prm,
   output logic             do_inval,
   output logic             do_fb,
   output logic             do_pd,
   output logic             do_ofs,
   output logic             do_release,
   output logic             do_valid,
   output logic             busy,
   output logic             done
);

   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] LOCK_LD   = CNT_W'(LOCK_CYC - 1);

   seq_state_t state_q, state_d;
   pll_param_t prm_q;
   logic       done_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:      if (start) state_d = ST_INVAL;
         ST_INVAL:     state_d = ST_WAIT_A;
         ST_WAIT_A:    if (tmr_expired) state_d = ST_WR_FB;
         ST_WR_FB:     state_d = ST_WR_PD;
         ST_WR_PD:     state_d = ST_WR_OFS;
         ST_WR_OFS:    state_d = ST_WAIT_B;
         ST_WAIT_B:    if (tmr_expired) state_d = ST_RELEASE;
         ST_RELEASE:   state_d = ST_WAIT_LOCK;
         ST_WAIT_LOCK: if (tmr_expired) state_d = ST_VALID;
         ST_VALID:     state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         prm_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= (state_q == ST_VALID);
         if (state_q == ST_IDLE && start) begin
            prm_q <= prm_in;
         end
      end
   end

   // Timer reload points: entry into each wait state
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = SETTLE_LD;
      case (state_q)
         ST_INVAL:   begin tmr_load = 1'b1; tmr_val = SETTLE_LD; end
         ST_WR_OFS:  begin tmr_load = 1'b1; tmr_val = SETTLE_LD; end
         ST_RELEASE: begin tmr_load = 1'b1; tmr_val = LOCK_LD;   end
         default:    ;
      endcase
   end

   assign do_inval   = (state_q == ST_INVAL);
   assign do_fb      = (state_q == ST_WR_FB);
   assign do_pd      = (state_q == ST_WR_PD);
   assign do_ofs     = (state_q == ST_WR_OFS);
   assign do_release = (state_q == ST_RELEASE);
   assign do_valid   = (state_q == ST_VALID);
   assign prm        = prm_q;
   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;

   // R8 a start seen while busy leaves the latched rate untouched
   ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(prm_q));

   // R8 a start seen while idle always opens a sequence
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

endmodule

// File: rtl/apll_cfg_regs.sv
module apll_cfg_regs
   import apll_seq_pkg::*;
#(
   parameter logic [CFG_W-1:0] CFG0_INIT = '0,
   parameter logic [CFG_W-1:0] CFG1_INIT = '0,
   parameter logic [CFG_W-1:0] CFG2_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pll_param_t       prm,
   input  logic             do_inval,
   input  logic             do_fb,
   input  logic             do_pd,
   input  logic             do_ofs,
   input  logic             do_release,
   input  logic             do_valid,
   output logic [CFG_W-1:0] cfg0,
   output logic [CFG_W-1:0] cfg1,
   output logic [CFG_W-1:0] cfg2
);

   localparam logic [CFG_W-1:0] FB_M  = field_mask(FB_LSB, FB_W);
   localparam logic [CFG_W-1:0] PD_M  = field_mask(PD_LSB, PD_W);
   localparam logic [CFG_W-1:0] OFS_M = field_mask(OFS_LSB, OFS_W);
   localparam logic [CFG_W-1:0] VAL_M = field_mask(VALID_BIT, 1);
   localparam logic [CFG_W-1:0] REL_M = field_mask(RELEASE_BIT, 1);
   localparam logic [CFG_W-1:0] CFG1_OWN = OFS_M | VAL_M | REL_M;

   logic [CFG_W-1:0] r0_q, r1_q, r2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r0_q <= CFG0_INIT;
         r1_q <= CFG1_INIT;
         r2_q <= CFG2_INIT;
      end else begin
         if (do_fb) begin
            r0_q <= (r0_q & ~FB_M) | ((CFG_W'(prm.fb) << FB_LSB) & FB_M);
         end
         if (do_pd) begin
            r2_q <= (r2_q & ~PD_M) | ((CFG_W'(prm.pd) << PD_LSB) & PD_M);
         end
         if (do_inval) begin
            r1_q <= r1_q & ~(VAL_M | REL_M);
         end else if (do_ofs) begin
            r1_q <= (r1_q & ~OFS_M) | ((CFG_W'(prm.ofs) << OFS_LSB) & OFS_M);
         end else if (do_release) begin
            r1_q <= r1_q | REL_M;
         end else if (do_valid) begin
            r1_q <= r1_q | VAL_M;
         end
      end
   end

   assign cfg0 = r0_q;
   assign cfg1 = r1_q;
   assign cfg2 = r2_q;

   // R5 parameter writes only happen while the PLL is held in reset
   ofs_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_fb || do_pd || do_ofs) |-> (!r1_q[RELEASE_BIT] && !r1_q[VALID_BIT]));

   // R9 unowned bits of every image stay at their reset values
   unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((r0_q & ~FB_M) == (CFG0_INIT & ~FB_M)) &&
      ((r1_q & ~CFG1_OWN) == (CFG1_INIT & ~CFG1_OWN)) &&
      ((r2_q & ~PD_M) == (CFG2_INIT & ~PD_M)));

endmodule

// File: rtl/apll_reprog_seq.sv
module apll_reprog_seq
   import apll_seq_pkg::*;
#(
   parameter int unsigned CLK_HZ    = 50_000_000,
   parameter int unsigned SETTLE_US = 1,
   parameter int unsigned LOCK_US   = 50,
   parameter int unsigned RATE_W    = 3,
   parameter logic [31:0] CFG0_INIT = 32'h1234_5678,
   parameter logic [31:0] CFG1_INIT = 32'hBC01_1234,
   parameter logic [31:0] CFG2_INIT = 32'h0000_5A91
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RATE_W-1:0] rate_sel,
   output logic [31:0]       cfg0,
   output logic [31:0]       cfg1,
   output logic [31:0]       cfg2,
   output logic              busy,
   output logic              done
);

   localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
   localparam int unsigned LOCK_CYC   = LOCK_US * CYC_PER_US;
   localparam int unsigned MAX_CYC    = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
   localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

   initial begin
      assert (CLK_HZ % 1_000_000 == 0 && CYC_PER_US >= 1)
         else $error("apll_reprog_seq: CLK_HZ must be a whole number of MHz");
      assert (SETTLE_US >= 1 && LOCK_US >= 1)
         else $error("apll_reprog_seq: delays must be at least 1 us");
   end

   pll_param_t       lut_prm, seq_prm;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             do_inval, do_fb, do_pd, do_ofs, do_release, do_valid;

   apll_rate_lut #(.RATE_W(RATE_W)) u_lut (
      .rate_sel (rate_sel),
      .prm      (lut_prm)
   );

   apll_delay_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   apll_seq_fsm #(
      .CNT_W      (CNT_W),
      .SETTLE_CYC (SETTLE_CYC),
      .LOCK_CYC   (LOCK_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .prm_in      (lut_prm),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .prm         (seq_prm),
      .do_inval    (do_inval),
      .do_fb       (do_fb),
      .do_pd       (do_pd),
      .do_ofs      (do_ofs),
      .do_release  (do_release),
      .do_valid    (do_valid),
      .busy        (busy),
      .done        (done)
   );

   apll_cfg_regs #(
      .CFG0_INIT (CFG0_INIT),
      .CFG1_INIT (CFG1_INIT),
      .CFG2_INIT (CFG2_INIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .prm        (seq_prm),
      .do_inval   (do_inval),
      .do_fb      (do_fb),
      .do_pd      (do_pd),
      .do_ofs     (do_ofs),
      .do_release (do_release),
      .do_valid   (do_valid),
      .cfg0       (cfg0),
      .cfg1       (cfg1),
      .cfg2       (cfg2)
   );

   // R10 done lasts a single cycle
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8 done coincides with the end of busy
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6 reset release happens while the offset is still invalid
   release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg1[31]) |-> !cfg1[16]);

   // R7 offset revalidation only with reset released, together with done
   revalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg1[16]) |-> (cfg1[31] && done));

endmodule

// File: tb/tb_apll_reprog_seq.sv
module tb_apll_reprog_seq;

   localparam int unsigned CLK_HZ = 50_000_000;
   localparam int unsigned N      = 50;     // 1 us at 50 MHz
   localparam int unsigned L      = 2500;   // 50 us at 50 MHz
   localparam logic [31:0] I0 = 32'h1234_5678;
   localparam logic [31:0] I1 = 32'hBC01_1234;
   localparam logic [31:0] I2 = 32'h0000_5A91;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  rate_sel = '0;
   logic [31:0] cfg0, cfg1, cfg2;
   logic        busy, done;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   apll_reprog_seq #(.CLK_HZ(CLK_HZ)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rate_sel(rate_sel),
      .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .busy(busy), .done(done)
   );

   typedef struct {
      int          at;
      logic [31:0] c0, c1, c2;
      logic        b, d;
      string       tag;
   } item_t;

   item_t q[$];
   item_t model;
   logic  mon_en = 1'b0;

   // ---------------- expected-value model ----------------
   function automatic void params(input int code, output logic [15:0] ofs,
                                  output logic [8:0] fb, output logic [6:0] pd);
      ofs = 16'h22B0; fb = 9'h1D;
      case (code)
         1: pd = 7'hC;
         2: pd = 7'h6;
         3: pd = 7'h3;
         default: begin ofs = 16'h0735; fb = 9'h1B; pd = 7'hC; end
      endcase
   endfunction

   task automatic push_if_changed(input int at, input item_t nxt, input string tag);
      if (nxt.c0 != model.c0 || nxt.c1 != model.c1 || nxt.c2 != model.c2 ||
          nxt.b != model.b || nxt.d != model.d) begin
         nxt.at  = at;
         nxt.tag = tag;
         q.push_back(nxt);
         model = nxt;
      end
   endtask

   // Driver: predicts the whole sequence, then issues start at base cycle
   task automatic run(input int code, input int poke_k, input int poke_code);
      logic [15:0] ofs; logic [8:0] fb; logic [6:0] pd;
      item_t x;
      int    b;
      params(code, ofs, fb, pd);
      b = cyc + 1;   // cycle count seen after edge 0
      x = model; x.b = 1'b1;
      push_if_changed(b, x, "R8 busy rise");
      x.c1 = x.c1 & ~32'h8001_0000;
      push_if_changed(b + 1, x, "R4 invalidate");
      x.c0 = (x.c0 & ~32'h0007_FC00) | (32'(fb) << 10);
      push_if_changed(b + N + 2, x, "R2/R3/R5 fb write");
      x.c2 = (x.c2 & ~32'h0000_007F) | 32'(pd);
      push_if_changed(b + N + 3, x, "R2/R3/R5 pd write");
      x.c1 = (x.c1 & ~32'h0000_FFFF) | 32'(ofs);
      push_if_changed(b + N + 4, x, "R2/R3/R5 ofs write");
      x.c1 = x.c1 | 32'h8000_0000;
      push_if_changed(b + 2*N + 5, x, "R6 release");
      x.c1 = x.c1 | 32'h0001_0000; x.b = 1'b0; x.d = 1'b1;
      push_if_changed(b + 2*N + 6 + L, x, "R7 revalidate+done");
      x.d = 1'b0;
      push_if_changed(b + 2*N + 7 + L, x, "R10 done fall");

      start = 1'b1; rate_sel = 3'(code);
      @(negedge clk);
      start = 1'b0; rate_sel = 3'(poke_code);
      if (poke_k >= 0) begin
         while (cyc < b - 1 + poke_k) @(negedge clk);
         start = 1'b1;               // R8: sampled while busy, must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      while (q.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R8 leftover expected events: actual %0d expected 0", q.size());
      end
   endtask

   // Monitor: compare every output change against the queue
   logic [31:0] p0, p1, p2;
   logic        pb, pd_;
   always @(negedge clk) begin
      if (mon_en) begin
         if (cfg0 != p0 || cfg1 != p1 || cfg2 != p2 || busy != pb || done != pd_) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R8/R9 unexpected change at %0d: actual %h %h %h b%0d d%0d expected no change",
                        cyc, cfg0, cfg1, cfg2, busy, done);
            end else begin
               item_t e;
               e = q.pop_front();
               if (e.at != cyc || e.c0 !== cfg0 || e.c1 !== cfg1 || e.c2 !== cfg2 ||
                   e.b !== busy || e.d !== done) begin
                  errors++;
                  $display("FAIL %s: actual @%0d %h %h %h b%0d d%0d expected @%0d %h %h %h b%0d d%0d",
                           e.tag, cyc, cfg0, cfg1, cfg2, busy, done,
                           e.at, e.c0, e.c1, e.c2, e.b, e.d);
               end
            end
         end
      end
      p0 <= cfg0; p1 <= cfg1; p2 <= cfg2; pb <= busy; pd_ <= done;
   end

   task automatic main_seq();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      checks++;
      if (cfg0 !== I0 || cfg1 !== I1 || cfg2 !== I2 || busy !== 1'b0 || done !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset state: actual %h %h %h b%0d d%0d expected %h %h %h b0 d0",
                  cfg0, cfg1, cfg2, busy, done, I0, I1, I2);
      end
      model.c0 = I0; model.c1 = I1; model.c2 = I2; model.b = 1'b0; model.d = 1'b0;
      p0 = cfg0; p1 = cfg1; p2 = cfg2; pb = busy; pd_ = done;
      mon_en = 1'b1;
      @(negedge clk);
      run(1, -1, 0);                 // R2 48 kHz
      run(6, -1, 0);                 // R3 unknown code -> 44.1 kHz
      run(2, 10, 3);                 // R2 96 kHz, R8 start mid-sequence
      run(3, 2*N + 6 + L, 1);        // R2 192 kHz, R8 start on last busy cycle
      run(0, -1, 0);                 // R2 44.1 kHz
      run(1, N + 3, 0);              // R2 48 kHz again, R8 start during writes
      run(7, -1, 0);                 // R3 highest unknown code
   endtask

   initial begin
      fork
         main_seq();
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule